// File: doc/BRIEF.md
# I2C Stuck-Data Bus Recovery Unit

This unit watches an I2C bus while the local master reports that no transfer is in progress. A bus is hung when SCL is high but SDA is held low by a slave that lost track of a byte. When that condition lasts for a programmable number of clock cycles, the unit takes over the clock line. It drives up to nine SCL pulses, each phase as long as the programmable half-period, so that the slave can finish its byte and let SDA go. SDA is sampled at the end of every SCL high phase, and the burst stops as soon as SDA reads high.

Once SDA has been released, the unit places a stop condition on the bus and reports success. If SDA is still low after the ninth pulse, it reports failure. When that option is enabled, it also holds a reset line toward the slave for a programmable number of cycles. Both line outputs are open-drain enables: a 1 pulls the wire low.

Top module: `i2cBusRecovery`

## Requirements
- R1: With `sclIn`=1, `sdaIn`=0 and `masterIdle`=1 held, `busy` is still 0 after `timeoutCycles` rising clock edges and is 1 after the next edge (`timeoutCycles` ≥ 1).
- R2: The timeout count restarts whenever `sdaIn` is 1, `sclIn` is 0 or `masterIdle` is 0, so no recovery starts unless the stuck condition is continuous for the full timeout.
- R3: During the pulse burst, each SCL low phase lasts exactly `halfPeriod` cycles (`halfPeriod` ≥ 1), and `sdaOe` stays 0.
- R4: SDA is sampled at the end of each SCL high phase. The burst ends after the first pulse whose high phase sees SDA high, and it never exceeds 9 pulses.
- R5: After SDA is released, the unit issues one stop. SCL is pulled low with SDA free, then SDA is pulled low, then SCL is released, then SDA is released while SCL is high. `sdaOe` never rises while SCL is released, so no start condition is created.
- R6: A recovery that ends with SDA released sets `done`=1 and `fail`=0. Both flags hold their value while idle and clear on the edge at which the next recovery begins. They are never both 1.
- R7: If SDA is still low at the end of the ninth high phase, `fail` is set. When `rstEnable`=1, `slaveRst` is 1 for exactly `rstPulseCycles` cycles before `busy` falls. When `rstEnable`=0, `slaveRst` never rises.
- R8: After reset, and whenever `busy`=0, `sclOe`, `sdaOe` and `slaveRst` are 0. After reset, `done` and `fail` are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| masterIdle | input | 1 | 1 while the local master runs no transfer |
| timeoutCycles | input | TMO_W | Stuck-low cycles before recovery starts |
| halfPeriod | input | HALF_W | Cycles per SCL phase |
| rstEnable | input | 1 | Enables the slave reset pulse on failure |
| rstPulseCycles | input | RST_W | Width of the slave reset pulse in cycles |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| slaveRst | output | 1 | Active-high reset toward the slave |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | Last recovery freed the bus |
| fail | output | 1 | Last recovery could not free the bus |

## Verification
A bench slave model holds SDA low until it has seen a chosen number of SCL rising edges, or until the slave reset arrives. The bench sweeps that count from 1 up past nine. A design that miscounted pulses would show a rise count other than K+1 on success, or would fail to flag a slave that never lets go. The bench also restarts the stuck condition one cycle short of the timeout, and holds it while the master is busy. A detector that does not clear its count would then start recovering too early, or while a transfer is running. It measures the first SCL low phase and the reset pulse width, which exposes off-by-one timer loads. It watches for SDA being pulled low while SCL is high, and checks that exactly one stop follows a success.

// File: rtl/i2cRecPkg.sv
package i2cRecPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLOW,
    ST_PHIGH,
    ST_SLOW,
    ST_SLOWD,
    ST_SHIGH,
    ST_SREL,
    ST_SRST
  } recStateT;

  typedef struct packed {
    logic watchEn;
    logic tmrLoadHalf;
    logic tmrLoadRst;
    logic pulseClr;
    logic pulseInc;
  } dpCtrlT;

endpackage

// File: rtl/i2cRecDatapath.sv
module i2cRecDatapath
  import i2cRecPkg::*;
#(
  parameter int TMO_W  = 16,
  parameter int HALF_W = 12,
  parameter int RST_W  = 12,
  parameter int NPULSE = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              masterIdle,
  input  logic [TMO_W-1:0]  timeoutCycles,
  input  logic [HALF_W-1:0] halfPeriod,
  input  logic [RST_W-1:0]  rstPulseCycles,
  input  dpCtrlT            ctrl,
  output logic              stuckHit,
  output logic              tmrDone,
  output logic              pulseLast
);

  localparam int TMR_W  = (HALF_W > RST_W) ? HALF_W : RST_W;
  localparam int PCNT_W = $clog2(NPULSE + 1);

  logic [TMO_W-1:0]  stuckCnt;
  logic [TMR_W-1:0]  phaseTmr;
  logic [PCNT_W-1:0] pulseCnt;
  logic              watchCond;

  // Deadlock signature: clock released high, data held low, no transfer.
  assign watchCond = ctrl.watchEn && sclIn && !sdaIn && masterIdle;
  assign stuckHit  = watchCond && (stuckCnt >= timeoutCycles);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stuckCnt <= '0;
    end else if (!watchCond) begin
      stuckCnt <= '0;
    end else if (stuckCnt < timeoutCycles) begin
      stuckCnt <= stuckCnt + TMO_W'(1);
    end
  end

  // One timer serves both the SCL phases and the reset pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseTmr <= '0;
    end else if (ctrl.tmrLoadHalf) begin
      phaseTmr <= TMR_W'(halfPeriod) - TMR_W'(1);
    end else if (ctrl.tmrLoadRst) begin
      phaseTmr <= TMR_W'(rstPulseCycles) - TMR_W'(1);
    end else if (phaseTmr != '0) begin
      phaseTmr <= phaseTmr - TMR_W'(1);
    end
  end

  assign tmrDone = (phaseTmr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (ctrl.pulseClr) begin
      pulseCnt <= '0;
    end else if (ctrl.pulseInc) begin
      pulseCnt <= pulseCnt + PCNT_W'(1);
    end
  end

  assign pulseLast = (pulseCnt == PCNT_W'(NPULSE - 1));

endmodule

// File: rtl/i2cRecControl.sv
module i2cRecControl
  import i2cRecPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sdaIn,
  input  logic   rstEnable,
  input  logic   stuckHit,
  input  logic   tmrDone,
  input  logic   pulseLast,
  output dpCtrlT ctrl,
  output logic   sclOe,
  output logic   sdaOe,
  output logic   slaveRst,
  output logic   busy,
  output logic   done,
  output logic   fail
);

  recStateT state, stateNxt;
  logic     setDone, setFail, clrFlags;

  always_comb begin
    stateNxt         = state;
    ctrl             = '0;
    ctrl.watchEn     = (state == ST_IDLE);
    setDone          = 1'b0;
    setFail          = 1'b0;
    clrFlags         = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (stuckHit) begin
          stateNxt         = ST_PLOW;
          ctrl.tmrLoadHalf = 1'b1;
          ctrl.pulseClr    = 1'b1;
          clrFlags         = 1'b1;
        end
      end
      ST_PLOW: begin
        if (tmrDone) begin
          stateNxt         = ST_PHIGH;
          ctrl.tmrLoadHalf = 1'b1;
        end
      end
      ST_PHIGH: begin
        if (tmrDone) begin
          if (sdaIn) begin
            stateNxt         = ST_SLOW;
            ctrl.tmrLoadHalf = 1'b1;
          end else if (pulseLast) begin
            if (rstEnable) begin
              stateNxt        = ST_SRST;
              ctrl.tmrLoadRst = 1'b1;
            end else begin
              stateNxt = ST_IDLE;
              setFail  = 1'b1;
            end
          end else begin
            stateNxt         = ST_PLOW;
            ctrl.tmrLoadHalf = 1'b1;
            ctrl.pulseInc    = 1'b1;
          end
        end
      end
      ST_SLOW: begin
        if (tmrDone) begin
          stateNxt         = ST_SLOWD;
          ctrl.tmrLoadHalf = 1'b1;
        end
      end
      ST_SLOWD: begin
        if (tmrDone) begin
          stateNxt         = ST_SHIGH;
          ctrl.tmrLoadHalf = 1'b1;
        end
      end
      ST_SHIGH: begin
        if (tmrDone) begin
          stateNxt         = ST_SREL;
          ctrl.tmrLoadHalf = 1'b1;
        end
      end
      ST_SREL: begin
        if (tmrDone) begin
          stateNxt = ST_IDLE;
          setDone  = 1'b1;
        end
      end
      ST_SRST: begin
        if (tmrDone) begin
          stateNxt = ST_IDLE;
          setFail  = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (clrFlags) begin
        done <= 1'b0;
        fail <= 1'b0;
      end else begin
        if (setDone) done <= 1'b1;
        if (setFail) fail <= 1'b1;
      end
    end
  end

  assign sclOe    = (state == ST_PLOW) || (state == ST_SLOW) || (state == ST_SLOWD);
  assign sdaOe    = (state == ST_SLOWD) || (state == ST_SHIGH);
  assign slaveRst = (state == ST_SRST);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/i2cBusRecovery.sv
module i2cBusRecovery
  import i2cRecPkg::*;
#(
  parameter int TMO_W  = 16,
  parameter int HALF_W = 12,
  parameter int RST_W  = 12,
  parameter int NPULSE = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              masterIdle,
  input  logic [TMO_W-1:0]  timeoutCycles,
  input  logic [HALF_W-1:0] halfPeriod,
  input  logic              rstEnable,
  input  logic [RST_W-1:0]  rstPulseCycles,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              slaveRst,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  dpCtrlT ctrl;
  logic   stuckHit, tmrDone, pulseLast;

  i2cRecDatapath #(
    .TMO_W (TMO_W),
    .HALF_W(HALF_W),
    .RST_W (RST_W),
    .NPULSE(NPULSE)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .sclIn         (sclIn),
    .sdaIn         (sdaIn),
    .masterIdle    (masterIdle),
    .timeoutCycles (timeoutCycles),
    .halfPeriod    (halfPeriod),
    .rstPulseCycles(rstPulseCycles),
    .ctrl          (ctrl),
    .stuckHit      (stuckHit),
    .tmrDone       (tmrDone),
    .pulseLast     (pulseLast)
  );

  i2cRecControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .sdaIn    (sdaIn),
    .rstEnable(rstEnable),
    .stuckHit (stuckHit),
    .tmrDone  (tmrDone),
    .pulseLast(pulseLast),
    .ctrl     (ctrl),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe),
    .slaveRst (slaveRst),
    .busy     (busy),
    .done     (done),
    .fail     (fail)
  );

endmodule

// File: rtl/i2cBusRecoveryChk.sv
module i2cBusRecoveryChk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic masterIdle,
  input logic rstEnable,
  input logic sclOe,
  input logic sdaOe,
  input logic slaveRst,
  input logic busy,
  input logic done,
  input logic fail
);

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(sclIn && !sdaIn && masterIdle)); // R1

  AST_NO_START_COND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> sclOe); // R5

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!done && !fail)); // R6

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail)); // R6

  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rstN)
    slaveRst |-> (rstEnable && busy && !sclOe && !sdaOe)); // R7

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe && !slaveRst)); // R8

  AST_NO_DATA_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && !$past(sclOe) && !$past(busy)) |-> !sdaOe); // R3

endmodule

bind i2cBusRecovery i2cBusRecoveryChk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaIn     (sdaIn),
  .masterIdle(masterIdle),
  .rstEnable (rstEnable),
  .sclOe     (sclOe),
  .sdaOe     (sdaOe),
  .slaveRst  (slaveRst),
  .busy      (busy),
  .done      (done),
  .fail      (fail)
);

// File: tb/tb_i2cBusRecovery.sv
`timescale 1ns/1ps
module tb_i2cBusRecovery;

  localparam int TMO_W  = 16;
  localparam int HALF_W = 12;
  localparam int RST_W  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterIdle = 1'b1;
  logic [TMO_W-1:0]  timeoutCycles = 16'd4;
  logic [HALF_W-1:0] halfPeriod = 12'd2;
  logic rstEnable = 1'b0;
  logic [RST_W-1:0]  rstPulseCycles = 12'd3;
  logic sclOe, sdaOe, slaveRst, busy, done, fail;

  // slave model
  logic armed = 1'b0;
  int   relAfter = 1;
  int   baseRises = 0;
  int   baseRst = 0;
  int   totalRises = 0;
  int   totalRstCyc = 0;
  int   totalStops = 0;
  int   totalStarts = 0;
  int   scenId = 0;
  int   capId = 0;
  int   firstLow = 0;
  int   lowRun = 0;
  logic prevScl = 1'b1;
  logic slaveHold;
  logic sclBus, sdaBus;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;

  assign slaveHold = armed && ((totalRises - baseRises) < relAfter) && (totalRstCyc == baseRst);
  assign sclBus    = !sclOe;
  assign sdaBus    = !(sdaOe || slaveHold);

  i2cBusRecovery dut (
    .clk           (clk),
    .rstN          (rstN),
    .sclIn         (sclBus),
    .sdaIn         (sdaBus),
    .masterIdle    (masterIdle),
    .timeoutCycles (timeoutCycles),
    .halfPeriod    (halfPeriod),
    .rstEnable     (rstEnable),
    .rstPulseCycles(rstPulseCycles),
    .sclOe         (sclOe),
    .sdaOe         (sdaOe),
    .slaveRst      (slaveRst),
    .busy          (busy),
    .done          (done),
    .fail          (fail)
  );

  always #5 clk = !clk;

  always @(posedge sclBus) totalRises <= totalRises + 1;
  always @(negedge sdaOe) if (sclBus && busy) totalStops <= totalStops + 1;
  always @(negedge sdaBus) if (sclBus && busy) totalStarts <= totalStarts + 1;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (slaveRst) totalRstCyc <= totalRstCyc + 1;
    if (!sclBus) lowRun <= lowRun + 1;
    else lowRun <= 0;
    if (sclBus && !prevScl && capId != scenId) begin
      firstLow <= lowRun;
      capId    <= scenId;
    end
    prevScl <= sclBus;
  end

  function automatic int expRises(int k);
    return (k <= 9) ? k + 1 : 9;
  endfunction

  function automatic int expFail(int k);
    return (k > 9) ? 1 : 0;
  endfunction

  task automatic check(input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  // One full stuck-slave scenario: slave releases after k SCL rises.
  task automatic runScenario(input int t, input int h, input int k, input bit re, input int rw);
    int startRst, startRises, startStops, startStarts, guard;
    @(negedge clk);
    timeoutCycles  = TMO_W'(t);
    halfPeriod     = HALF_W'(h);
    rstEnable      = re;
    rstPulseCycles = RST_W'(rw);
    masterIdle     = 1'b1;
    relAfter       = k;
    baseRises      = totalRises;
    baseRst        = totalRstCyc;
    startRst       = totalRstCyc;
    startRises     = totalRises;
    startStops     = totalStops;
    startStarts    = totalStarts;
    scenId         = scenId + 1;
    armed          = 1'b1;
    repeat (t) @(posedge clk);
    @(negedge clk);
    check(busy, 0, "R1 busy before timeout");
    @(posedge clk);
    @(negedge clk);
    check(busy, 1, "R1 busy after timeout");
    check(done + fail, 0, "R6 flags cleared at start");
    guard = 0;
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(busy, 0, "R4 recovery terminates");
    check(totalRises - startRises, expRises(k), "R4 SCL rises in recovery");
    check(firstLow, h, "R3 first SCL low phase");
    check(totalStarts - startStarts, 0, "R5 no SDA fall while SCL high");
    if (expFail(k) == 0) begin
      check(done, 1, "R6 done on success");
      check(fail, 0, "R6 fail clear on success");
      check(totalStops - startStops, 1, "R5 one stop issued");
      check(totalRstCyc - startRst, 0, "R7 no reset on success");
    end else begin
      check(fail, 1, "R7 fail after nine pulses");
      check(done, 0, "R6 done clear on failure");
      check(totalRstCyc - startRst, re ? rw : 0, "R7 reset pulse width");
    end
    armed = 1'b0;
    @(negedge clk);
    check(sclOe + sdaOe + slaveRst, 0, "R8 lines free when idle");
    repeat (3) @(negedge clk);
    check(done, expFail(k) ? 0 : 1, "R6 done holds while idle");
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        misses++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    check(sclOe + sdaOe + slaveRst + busy + done + fail, 0, "R8 reset state");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy, 0, "R8 idle after reset");

    // R2: master active blocks detection
    timeoutCycles = 16'd3;
    masterIdle    = 1'b0;
    relAfter      = 1;
    baseRises     = totalRises;
    baseRst       = totalRstCyc;
    armed         = 1'b1;
    repeat (12) @(negedge clk);
    check(busy, 0, "R2 no recovery while master active");
    armed      = 1'b0;
    masterIdle = 1'b1;
    @(negedge clk);

    // R2: short SDA high blip restarts the count
    timeoutCycles = 16'd5;
    halfPeriod    = 12'd1;
    armed         = 1'b1;
    repeat (4) @(negedge clk);
    armed = 1'b0;
    @(negedge clk);
    armed = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(busy, 0, "R2 count restarted after SDA high");
    @(posedge clk);
    @(negedge clk);
    check(busy, 1, "R2 recovery after full timeout");
    while (busy) @(negedge clk);
    armed = 1'b0;
    @(negedge clk);

    // directed corners
    runScenario(1, 1, 1, 1'b0, 2);
    runScenario(3, 2, 9, 1'b1, 2);
    runScenario(2, 3, 10, 1'b0, 2);
    runScenario(4, 1, 12, 1'b1, 5);
    runScenario(1, 4, 10, 1'b1, 1);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      runScenario(1 + int'($urandom_range(19)), 1 + int'($urandom_range(3)),
                  1 + int'($urandom_range(11)), bit'($urandom_range(1)),
                  1 + int'($urandom_range(5)));
    end
    finishRun();
  end

endmodule